// File: doc/BRIEF.md
# Rename Stage Thread Controller

This block is the control state machine for one thread of a superscalar rename stage. Each cycle it works out how many instructions the thread may rename. The limit comes from the rename width, from how many instructions are waiting, and from the room left in the reorder buffer (ROB), the issue queue (IQ) and the load/store queue (LSQ). The controller can also hold the thread instead: it parks unrenamed instructions in a skid buffer, stalls behind a barrier instruction, or runs a squash. It does no register mapping. It only produces counts and controls, which the datapath around it acts on.

The skid buffer storage lives outside the block. The controller drives its push, pop and clear counts and keeps its own copy of the occupancy. Instructions held in the skid buffer are older than anything arriving from decode, so they are always renamed first. The barrier flags describe the oldest instruction offered this cycle, whichever source it comes from. Decode is expected to send nothing while the block signal is high.

Top module: `rename_thread_ctrl`

## Requirements
- R1: The state is visible on `state_o` with the encoding Running=0, Idle=1, StartSquash=2, Squashing=3, Blocked=4, Unblocking=5, SerializeStall=6. Reset leaves the thread in Idle with an empty skid buffer.
- R2: In Running, Idle or Unblocking with no stall, `ren_cnt_o` is the smallest of: waiting instructions (skid plus decode), the width limit, and each structure's effective free count. The width limit is WIDTH, or 1 when `ser_after_i` is high. In every other state `ren_cnt_o` is 0.
- R3: A structure's effective free count is its free input minus the number renamed in the previous cycle, floored at 0. A structure is short when its effective free count is below the wanted count. `stall_cause_o` names the first short structure, checking ROB=0 first, then IQ=1, then LSQ=2, and gives NONE=3 when none is short. In StartSquash and Squashing it reads NONE. An active state whose rename is cut by a short structure moves to Blocked.
- R4: In an active state, `exe_stall_i` or `cmt_stall_i` renames nothing, pushes every decode instruction into the skid buffer, and moves to Blocked. Either stall alone is enough.
- R5: `block_o` is high while the state is Blocked or SerializeStall, or while the skid buffer holds any instruction.
- R6: Blocked moves to Unblocking only in a cycle with no execute or commit stall and a cause of NONE. Until then it pushes decode input into the skid buffer.
- R7: Renamed instructions come from the skid buffer first (`skid_pop_o`) and then from decode. Decode instructions that are not renamed are pushed. The next state is Unblocking while the skid buffer is not empty, and Running or Idle once it is empty, depending on whether anything was renamed.
- R8: When the oldest waiting instruction is a barrier and the ROB is not empty, or the previous cycle renamed anything, the thread renames nothing, pushes decode input, and moves to SerializeStall. It leaves SerializeStall for Unblocking in the first cycle where the ROB is empty and nothing was renamed the cycle before.
- R9: A serialize-after instruction is renamed on its own. It sets a pending flag that makes the next instruction renamed behave as a barrier. The flag is cleared when a later rename happens without `ser_after_i`, and by StartSquash.
- R10: `squash_i` takes priority in every state: no rename, no push, and StartSquash next. StartSquash lasts one cycle, pulses `skid_clr_o`, and then moves to Squashing. Squashing returns to Running on `squash_done_i`. Decode input is dropped in both squash states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_cnt_i | input | clog2(WIDTH+1) | Valid instructions offered by decode this cycle |
| rob_free_i | input | FREE_W | ROB free entries |
| iq_free_i | input | FREE_W | IQ free entries |
| lsq_free_i | input | FREE_W | LSQ free entries |
| exe_stall_i | input | 1 | Stall request from execute |
| cmt_stall_i | input | 1 | Stall request from commit |
| squash_i | input | 1 | Squash request |
| squash_done_i | input | 1 | Squash finished |
| rob_empty_i | input | 1 | ROB holds no instruction of this thread |
| ser_i | input | 1 | Oldest waiting instruction is a barrier |
| ser_after_i | input | 1 | Oldest waiting instruction is serialize-after |
| ren_cnt_o | output | clog2(WIDTH+1) | Instructions renamed this cycle |
| skid_push_o | output | clog2(WIDTH+1) | Decode instructions to push into the skid buffer |
| skid_pop_o | output | clog2(WIDTH+1) | Skid entries consumed by rename |
| skid_clr_o | output | 1 | Discard the whole skid buffer |
| block_o | output | 1 | Tell decode to hold |
| stall_cause_o | output | 2 | First short structure: ROB=0, IQ=1, LSQ=2, NONE=3 |
| state_o | output | 3 | Thread state code |

## Verification
The assertions check, on every cycle, the properties that are local to one cycle or one step:
- the rename count never exceeds the width or the raw ROB room;
- either stall request, or an unready barrier, forces a zero rename;
- a serialize-after instruction renames alone;
- a push always raises the block signal on the next cycle;
- a squash always enters its one-cycle StartSquash step.

Only the bench's scenarios can show the history-dependent behaviour: the in-flight subtraction from the previous cycle, skid-first draining over several cycles, the path from Blocked through Unblocking, and the pending serialize flag stalling the following instruction. For these the bench compares every output with its reference model on every cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_IDLE     = 3'd1,
    ST_SQ_START = 3'd2,
    ST_SQ       = 3'd3,
    ST_BLK      = 3'd4,
    ST_UNBLK    = 3'd5,
    ST_SER      = 3'd6
  } rt_state_e;

  // order is priority: lower index reported first
  typedef enum logic [1:0] {
    CS_ROB  = 2'd0,
    CS_IQ   = 2'd1,
    CS_LSQ  = 2'd2,
    CS_NONE = 2'd3
  } cause_e;

  localparam int NUM_STRUCT = 3;
endpackage

// File: rtl/rtc_capacity.sv
module rtc_capacity
  import rtc_pkg::*;
#(
  parameter int FREE_W = 6,
  parameter int CW     = 3
) (
  input  logic [NUM_STRUCT-1:0][FREE_W-1:0] free_i,
  input  logic [CW-1:0]                     inflight_i,
  input  logic [CW-1:0]                     want_i,
  output logic [CW-1:0]                     cap_o,
  output cause_e                            cause_o
);
  localparam int EW = (FREE_W > CW) ? FREE_W : CW;

  logic [NUM_STRUCT-1:0][EW-1:0] eff;
  logic [NUM_STRUCT-1:0]         short_s;

  for (genvar s = 0; s < NUM_STRUCT; s++) begin : g_struct
    always_comb begin
      if (EW'(free_i[s]) > EW'(inflight_i)) eff[s] = EW'(free_i[s]) - EW'(inflight_i);
      else                                  eff[s] = '0;
      short_s[s] = eff[s] < EW'(want_i);
    end
  end

  always_comb begin
    logic [EW-1:0] m;
    m = EW'(want_i);
    for (int s = 0; s < NUM_STRUCT; s++)
      if (eff[s] < m) m = eff[s];
    cap_o = CW'(m);
  end

  always_comb begin
    cause_o = CS_NONE;
    for (int s = NUM_STRUCT - 1; s >= 0; s--)
      if (short_s[s]) cause_o = cause_e'(s);
  end
endmodule

// File: rtl/rtc_skid_track.sv
module rtc_skid_track #(
  parameter int CW = 3,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [CW-1:0] push_i,
  input  logic [CW-1:0] pop_i,
  output logic [SW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + SW'(push_i) - SW'(pop_i);
  end
endmodule

// File: rtl/rtc_fsm.sv
module rtc_fsm
  import rtc_pkg::*;
#(
  parameter int CW = 3,
  parameter int SW = 4,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] dec_cnt_i,
  input  logic [SW-1:0] skid_cnt_i,
  input  logic [CW-1:0] want_i,
  input  logic [CW-1:0] cap_i,
  input  cause_e        cause_i,
  input  logic          exe_stall_i,
  input  logic          cmt_stall_i,
  input  logic          squash_i,
  input  logic          squash_done_i,
  input  logic          rob_empty_i,
  input  logic          ser_i,
  input  logic          ser_after_i,
  output logic [CW-1:0] ren_cnt_o,
  output logic [CW-1:0] push_o,
  output logic [CW-1:0] pop_o,
  output logic          clr_o,
  output logic [CW-1:0] inflight_o,
  output rt_state_e     state_o,
  output cause_e        cause_o,
  output logic          block_o
);
  rt_state_e     state_q, state_d;
  logic [CW-1:0] inflight_q;
  logic          pend_q, pend_d;

  logic [AW-1:0] avail, skid_after;
  logic [CW-1:0] from_dec;
  logic          barrier, ready, stall;

  assign avail   = AW'(skid_cnt_i) + AW'(dec_cnt_i);
  assign barrier = ser_i | pend_q;
  assign ready   = rob_empty_i && (inflight_q == '0);
  assign stall   = exe_stall_i | cmt_stall_i;

  always_comb begin
    ren_cnt_o  = '0;
    push_o     = '0;
    pop_o      = '0;
    clr_o      = 1'b0;
    cause_o    = CS_NONE;
    state_d    = state_q;
    pend_d     = pend_q;
    from_dec   = '0;
    skid_after = '0;
    unique case (state_q)
      ST_SQ_START: begin
        clr_o   = 1'b1;
        pend_d  = 1'b0;
        state_d = ST_SQ;
      end
      ST_SQ: if (squash_done_i) state_d = ST_RUN;
      ST_BLK: begin
        push_o  = dec_cnt_i;
        cause_o = cause_i;
        if (!stall && cause_i == CS_NONE) state_d = ST_UNBLK;
      end
      ST_SER: begin
        push_o  = dec_cnt_i;
        cause_o = cause_i;
        if (ready) state_d = ST_UNBLK;
      end
      default: begin
        cause_o = cause_i;
        if (stall) begin
          push_o  = dec_cnt_i;
          state_d = ST_BLK;
        end else if (avail != '0 && barrier && !ready) begin
          push_o  = dec_cnt_i;
          state_d = ST_SER;
        end else begin
          ren_cnt_o  = cap_i;
          pop_o      = (AW'(cap_i) <= AW'(skid_cnt_i)) ? cap_i : CW'(skid_cnt_i);
          from_dec   = cap_i - pop_o;
          push_o     = dec_cnt_i - from_dec;
          skid_after = AW'(skid_cnt_i) - AW'(pop_o) + AW'(push_o);
          if (cap_i < want_i)        state_d = ST_BLK;
          else if (skid_after != '0) state_d = ST_UNBLK;
          else if (cap_i != '0)      state_d = ST_RUN;
          else                       state_d = ST_IDLE;
          if (cap_i != '0) pend_d = ser_after_i;
        end
      end
    endcase
    if (squash_i) begin
      ren_cnt_o = '0;
      push_o    = '0;
      pop_o     = '0;
      clr_o     = 1'b0;
      cause_o   = CS_NONE;
      pend_d    = pend_q;
      state_d   = ST_SQ_START;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      inflight_q <= '0;
      pend_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      inflight_q <= ren_cnt_o;
      pend_q     <= pend_d;
    end
  end

  assign state_o    = state_q;
  assign inflight_o = inflight_q;
  assign block_o    = (state_q == ST_BLK) || (state_q == ST_SER) || (skid_cnt_i != '0);
endmodule

// File: rtl/rename_thread_ctrl.sv
module rename_thread_ctrl
  import rtc_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int SKID_DEPTH = 8,
  parameter int FREE_W     = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [$clog2(WIDTH+1)-1:0]   dec_cnt_i,
  input  logic [FREE_W-1:0]            rob_free_i,
  input  logic [FREE_W-1:0]            iq_free_i,
  input  logic [FREE_W-1:0]            lsq_free_i,
  input  logic                         exe_stall_i,
  input  logic                         cmt_stall_i,
  input  logic                         squash_i,
  input  logic                         squash_done_i,
  input  logic                         rob_empty_i,
  input  logic                         ser_i,
  input  logic                         ser_after_i,
  output logic [$clog2(WIDTH+1)-1:0]   ren_cnt_o,
  output logic [$clog2(WIDTH+1)-1:0]   skid_push_o,
  output logic [$clog2(WIDTH+1)-1:0]   skid_pop_o,
  output logic                         skid_clr_o,
  output logic                         block_o,
  output logic [1:0]                   stall_cause_o,
  output logic [2:0]                   state_o
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam int SW = $clog2(SKID_DEPTH + 1);
  localparam int AW = $clog2(SKID_DEPTH + WIDTH + 1);

  logic [SW-1:0] skid_cnt;
  logic [CW-1:0] want, cap, inflight, lim;
  logic [AW-1:0] avail;
  cause_e        cause, cause_vis;
  rt_state_e     state;
  logic [NUM_STRUCT-1:0][FREE_W-1:0] free_vec;

  assign free_vec = {lsq_free_i, iq_free_i, rob_free_i};
  assign lim      = ser_after_i ? CW'(1) : CW'(WIDTH);
  assign avail    = AW'(skid_cnt) + AW'(dec_cnt_i);
  assign want     = (avail < AW'(lim)) ? CW'(avail) : lim;

  rtc_capacity #(.FREE_W(FREE_W), .CW(CW)) i_capacity (
    .free_i     (free_vec),
    .inflight_i (inflight),
    .want_i     (want),
    .cap_o      (cap),
    .cause_o    (cause)
  );

  rtc_fsm #(.CW(CW), .SW(SW), .AW(AW)) i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .dec_cnt_i     (dec_cnt_i),
    .skid_cnt_i    (skid_cnt),
    .want_i        (want),
    .cap_i         (cap),
    .cause_i       (cause),
    .exe_stall_i   (exe_stall_i),
    .cmt_stall_i   (cmt_stall_i),
    .squash_i      (squash_i),
    .squash_done_i (squash_done_i),
    .rob_empty_i   (rob_empty_i),
    .ser_i         (ser_i),
    .ser_after_i   (ser_after_i),
    .ren_cnt_o     (ren_cnt_o),
    .push_o        (skid_push_o),
    .pop_o         (skid_pop_o),
    .clr_o         (skid_clr_o),
    .inflight_o    (inflight),
    .state_o       (state),
    .cause_o       (cause_vis),
    .block_o       (block_o)
  );

  rtc_skid_track #(.CW(CW), .SW(SW)) i_skid (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (skid_clr_o),
    .push_i (skid_push_o),
    .pop_i  (skid_pop_o),
    .cnt_o  (skid_cnt)
  );

  assign state_o       = state;
  assign stall_cause_o = cause_vis;
endmodule

// File: rtl/rename_thread_ctrl_chk.sv
module rename_thread_ctrl_chk #(
  parameter int WIDTH      = 4,
  parameter int SKID_DEPTH = 8,
  parameter int FREE_W     = 6
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [$clog2(WIDTH+1)-1:0] dec_cnt_i,
  input logic [FREE_W-1:0]          rob_free_i,
  input logic [FREE_W-1:0]          iq_free_i,
  input logic [FREE_W-1:0]          lsq_free_i,
  input logic                       exe_stall_i,
  input logic                       cmt_stall_i,
  input logic                       squash_i,
  input logic                       squash_done_i,
  input logic                       rob_empty_i,
  input logic                       ser_i,
  input logic                       ser_after_i,
  input logic [$clog2(WIDTH+1)-1:0] ren_cnt_o,
  input logic [$clog2(WIDTH+1)-1:0] skid_push_o,
  input logic [$clog2(WIDTH+1)-1:0] skid_pop_o,
  input logic                       skid_clr_o,
  input logic                       block_o,
  input logic [1:0]                 stall_cause_o,
  input logic [2:0]                 state_o
);
  localparam int EW = ($clog2(WIDTH+1) > FREE_W) ? $clog2(WIDTH+1) : FREE_W;

  // R2
  ren_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ren_cnt_o) <= WIDTH);

  // R3
  rob_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    EW'(ren_cnt_o) <= EW'(rob_free_i));

  // R4
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exe_stall_i || cmt_stall_i) |-> ren_cnt_o == '0);

  // R5
  push_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skid_push_o != '0 && !squash_i) |=> block_o);

  // R8
  barrier_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_i && !rob_empty_i) |-> ren_cnt_o == '0);

  // R9
  after_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_after_i |-> ren_cnt_o <= 1);

  // R10
  squash_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> state_o == 3'd2);

  // R10
  squash_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && !squash_i) |=> state_o == 3'd3);
endmodule

bind rename_thread_ctrl rename_thread_ctrl_chk #(
  .WIDTH(WIDTH), .SKID_DEPTH(SKID_DEPTH), .FREE_W(FREE_W)
) i_rename_thread_ctrl_chk (.*);

// File: tb/test_rename_thread_ctrl.sv
module test_rename_thread_ctrl;
  localparam int W  = 4;
  localparam int D  = 8;
  localparam int FW = 6;
  localparam int CW = $clog2(W + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [CW-1:0] dec_cnt_i = '0;
  logic [FW-1:0] rob_free_i = '0, iq_free_i = '0, lsq_free_i = '0;
  logic exe_stall_i = 0, cmt_stall_i = 0, squash_i = 0, squash_done_i = 0;
  logic rob_empty_i = 0, ser_i = 0, ser_after_i = 0;
  logic [CW-1:0] ren_cnt_o, skid_push_o, skid_pop_o;
  logic skid_clr_o, block_o;
  logic [1:0] stall_cause_o;
  logic [2:0] state_o;

  always #10 clk_i = ~clk_i;

  rename_thread_ctrl #(.WIDTH(W), .SKID_DEPTH(D), .FREE_W(FW)) i_rename_thread_ctrl (.*);

  int n_tests = 0, n_fail = 0;
  int m_state, m_skid, m_infl, m_pend;
  int e_ren, e_push, e_pop, e_clr, e_cause, e_block;
  int n_state, n_skid, n_pend;
  int s_ren;

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_eval();
    int avail, lim, want, cause, cap, pop, push, dec;
    int eff[3];
    bit bar, ready, stall;
    dec   = int'(dec_cnt_i);
    avail = m_skid + dec;
    lim   = ser_after_i ? 1 : W;
    want  = (avail < lim) ? avail : lim;
    eff[0] = (int'(rob_free_i) > m_infl) ? int'(rob_free_i) - m_infl : 0;
    eff[1] = (int'(iq_free_i)  > m_infl) ? int'(iq_free_i)  - m_infl : 0;
    eff[2] = (int'(lsq_free_i) > m_infl) ? int'(lsq_free_i) - m_infl : 0;
    cause = 3;
    cap   = want;
    for (int k = 2; k >= 0; k--) if (eff[k] < want) cause = k;
    for (int k = 0; k < 3; k++) if (eff[k] < cap) cap = eff[k];
    bar   = ser_i || (m_pend != 0);
    ready = rob_empty_i && (m_infl == 0);
    stall = exe_stall_i || cmt_stall_i;
    e_ren = 0; pop = 0; push = 0; e_clr = 0; e_cause = 3;
    e_block = (m_state == 4 || m_state == 6 || m_skid != 0) ? 1 : 0;
    n_state = m_state; n_pend = m_pend;
    if (squash_i) n_state = 2;
    else case (m_state)
      2: begin e_clr = 1; n_pend = 0; n_state = 3; end
      3: if (squash_done_i) n_state = 0;
      4: begin push = dec; e_cause = cause; if (!stall && cause == 3) n_state = 5; end
      6: begin push = dec; e_cause = cause; if (ready) n_state = 5; end
      default: begin
        e_cause = cause;
        if (stall) begin push = dec; n_state = 4; end
        else if (avail > 0 && bar && !ready) begin push = dec; n_state = 6; end
        else begin
          e_ren = cap;
          pop   = (cap < m_skid) ? cap : m_skid;
          push  = dec - (cap - pop);
          if (cap < want) n_state = 4;
          else if (m_skid - pop + push > 0) n_state = 5;
          else n_state = (cap > 0) ? 0 : 1;
          if (cap > 0) n_pend = ser_after_i ? 1 : 0;
        end
      end
    endcase
    e_push = push; e_pop = pop;
    n_skid = e_clr ? 0 : m_skid - pop + push;
  endtask

  task automatic step();
    if (block_o) dec_cnt_i = '0;
    #5;
    model_eval();
    chk("R1 state", int'(state_o), m_state);
    chk("R2 ren_cnt", int'(ren_cnt_o), e_ren);
    chk("R3 cause", int'(stall_cause_o), e_cause);
    chk("R4 push", int'(skid_push_o), e_push);
    chk("R5 block", int'(block_o), e_block);
    chk("R7 pop", int'(skid_pop_o), e_pop);
    chk("R10 clr", int'(skid_clr_o), e_clr);
    s_ren = int'(ren_cnt_o);
    @(posedge clk_i);
    m_state = n_state; m_skid = n_skid; m_infl = e_ren; m_pend = n_pend;
    @(negedge clk_i);
  endtask

  task automatic frees(int r, int q, int l);
    rob_free_i = FW'(r); iq_free_i = FW'(q); lsq_free_i = FW'(l);
  endtask

  initial begin
    m_state = 1; m_skid = 0; m_infl = 0; m_pend = 0;
    frees(20, 20, 20);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #5;
    chk("R1 reset state", int'(state_o), 1);
    chk("R5 reset block", int'(block_o), 0);
    @(negedge clk_i);

    dec_cnt_i = 4; step();
    chk("R2 full width", s_ren, 4);
    // ROB short after in-flight subtraction: 5-4 = 1
    frees(5, 20, 20); step();
    chk("R3 rob limited", s_ren, 1);
    chk("R3 to blocked", int'(state_o), 4);
    frees(20, 20, 20); step();
    chk("R6 to unblocking", int'(state_o), 5);
    step();
    chk("R7 drained to running", int'(state_o), 0);
    // IQ then LSQ shortage
    dec_cnt_i = 4; frees(20, 3, 20); step();
    frees(20, 20, 20); step(); step();
    dec_cnt_i = 4; frees(20, 20, 2); step();
    frees(20, 20, 20); step(); step();
    // barrier
    dec_cnt_i = 2; ser_i = 1; rob_empty_i = 0; step();
    chk("R8 serialize stall", int'(state_o), 6);
    step();
    chk("R8 held", int'(state_o), 6);
    rob_empty_i = 1; step();
    chk("R8 release", int'(state_o), 5);
    step(); ser_i = 0;
    // serialize-after
    dec_cnt_i = 3; ser_after_i = 1; rob_empty_i = 0; step();
    chk("R9 single", s_ren, 1);
    ser_after_i = 0; step();
    chk("R9 pending barrier", int'(state_o), 6);
    rob_empty_i = 1; step(); step();
    // stalls
    dec_cnt_i = 2; exe_stall_i = 1; step();
    chk("R4 exe stall", int'(state_o), 4);
    step(); exe_stall_i = 0; cmt_stall_i = 1; step();
    chk("R4 cmt stall holds", int'(state_o), 4);
    cmt_stall_i = 0; step(); step();
    // squash
    dec_cnt_i = 3; squash_i = 1; step();
    chk("R10 start", int'(state_o), 2);
    squash_i = 0; step();
    chk("R10 squashing", int'(state_o), 3);
    step(); squash_done_i = 1; step(); squash_done_i = 0;
    chk("R10 back to running", int'(state_o), 0);

    for (int i = 0; i < 4000; i++) begin
      dec_cnt_i     = CW'($urandom_range(0, W));
      frees($urandom_range(0, 12), $urandom_range(0, 12), $urandom_range(0, 12));
      exe_stall_i   = ($urandom_range(0, 9) == 0);
      cmt_stall_i   = ($urandom_range(0, 11) == 0);
      squash_i      = ($urandom_range(0, 39) == 0);
      squash_done_i = ($urandom_range(0, 1) == 0);
      rob_empty_i   = ($urandom_range(0, 1) == 0);
      ser_i         = ($urandom_range(0, 9) == 0);
      ser_after_i   = ($urandom_range(0, 9) == 0);
      step();
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule